// File: doc/BRIEF.md
# External Interrupt Pin Sense Controller

This block sits between eight external interrupt pins and a downstream interrupt distributor. Each pin is brought into the core clock domain by a two-stage synchroniser. It is then qualified by its own programmable sense mode: level low, falling edge, rising edge or both edges. The result drives one registered, active-high request line per pin, which the distributor consumes as a level.

In the three edge modes a matching edge sets a sticky status bit, and the request stays high until software clears that bit. In level-low mode the request simply follows the synchronised pin: it is high while the pin is low and needs no clearing.

A small 32-bit register port configures the pins and services them. A status word holds one bit per pin; writing 0 to a bit clears it and writing 1 leaves it alone. A sense-select word holds a 2-bit mode field per pin. When a new edge and a clear of the same bit land in the same cycle, the edge wins, so no event is lost.

Top module: `ext_irq_sense`

## Requirements
- R1: After a synchronous active-high reset every sense field is 0 (level low), every status bit and request is 0, and read data is 0; the synchroniser resets to the idle-high pin level.
- R2: The sense word at offset 0x14 holds pin n's mode in bits [2n+1:2n]; it is written with a full write and reads back in bits [15:0], upper bits 0. Codes: 0 = level low, 1 = falling edge, 2 = rising edge, 3 = both edges.
- R3: In level-low mode (code 0) request n is high exactly while the synchronised pin is low, three clock edges after the pin changes; writes to the status word have no effect on it.
- R4: In falling-edge mode (code 1) a high-to-low pin transition sets status n, which then stays set until cleared.
- R5: In rising-edge mode (code 2) a low-to-high pin transition sets status n, which stays set until cleared.
- R6: In both-edges mode (code 3) either pin transition sets status n, which stays set until cleared.
- R7: A pin transition in the direction its edge mode does not select leaves status n unchanged.
- R8: The status word at offset 0x10 reads the per-pin status in bits [7:0] (bit n = pin n, upper bits 0); in edge modes a write with bit n = 0 clears status n, and bit n = 1 leaves it unchanged.
- R9: If a matching edge on pin n is detected in the same cycle as a write that clears bit n, status n ends up set.
- R10: Request n equals status n; read data is registered and shows the addressed word one clock after the address is presented; any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 8 | Asynchronous external interrupt pins |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data for the offset of the previous cycle |
| irq_req | output | 8 | Active-high level requests, one per pin |

## Verification
The sharpest corner is an edge arriving in the very cycle software clears its bit. A design that lets the clear win drops that interrupt for good, and the bench lines the two up exactly to catch it.

Edges in the direction a mode does not select are driven on purpose. A decoder with a swapped or inverted mode code would raise requests on them. Status writes are also made in level-low mode, where a design that wrongly latched or cleared the level bit would show a stuck or missing request.

Random mixed per-pin modes, pin patterns and partial clear masks are checked against a bench model. That model exposes a misplaced sense field, a clear acting on 1 instead of 0, and a sticky bit that fails to hold.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  typedef enum logic [1:0] {
    SNS_LVL_LO = 2'd0,
    SNS_FALL   = 2'd1,
    SNS_RISE   = 2'd2,
    SNS_BOTH   = 2'd3
  } sense_e;
endpackage

// File: rtl/xirq_sync.sv
// Two-stage synchroniser plus one history stage for edge comparison.
module xirq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] s_q,
  output logic [W-1:0] p_q
);
  logic [W-1:0] m_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_q <= '1;
      s_q <= '1;
      p_q <= '1;
    end else begin
      m_q <= d;
      s_q <= m_q;
      p_q <= s_q;
    end
  end
endmodule

// File: rtl/xirq_chan.sv
// One pin: sense decode and status bit.
module xirq_chan
  import xirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       s,
  input  logic       p,
  input  logic       clr,
  output logic       stat_q
);
  logic hit;
  logic nxt;

  always_comb begin
    hit = 1'b0;
    case (sense_e'(mode))
      SNS_FALL:  hit = p & ~s;
      SNS_RISE:  hit = ~p & s;
      SNS_BOTH:  hit = p ^ s;
      default:   hit = 1'b0;
    endcase
    if (sense_e'(mode) == SNS_LVL_LO) nxt = ~s;
    else                              nxt = hit | (stat_q & ~clr);
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= 1'b0;
    else     stat_q <= nxt;
  end
endmodule

// File: rtl/xirq_regs.sv
// Register decode: sense word, clear vector, registered read mux.
module xirq_regs #(
  parameter int          N_PINS    = 8,
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 32,
  parameter logic [7:0]  STAT_OFS  = 8'h10,
  parameter logic [7:0]  SENSE_OFS = 8'h14
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [N_PINS-1:0]     stat,
  output logic [2*N_PINS-1:0]   sense_q,
  output logic [N_PINS-1:0]     clr,
  output logic [DATA_W-1:0]     rdata
);
  localparam int SENSE_W = 2 * N_PINS;

  logic hit_stat;
  logic hit_sense;

  assign hit_stat  = (addr == ADDR_W'(STAT_OFS));
  assign hit_sense = (addr == ADDR_W'(SENSE_OFS));
  assign clr       = (we && hit_stat) ? ~wdata[N_PINS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_q <= '0;
      rdata   <= '0;
    end else begin
      if (we && hit_sense) sense_q <= wdata[SENSE_W-1:0];
      if (hit_stat)       rdata <= DATA_W'(stat);
      else if (hit_sense) rdata <= DATA_W'(sense_q);
      else                rdata <= '0;
    end
  end
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense #(
  parameter int N_PINS = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] pin_i,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_PINS-1:0] irq_req
);
  localparam int SENSE_W = 2 * N_PINS;

  logic [N_PINS-1:0]  pin_s;
  logic [N_PINS-1:0]  pin_p;
  logic [N_PINS-1:0]  clr_vec;
  logic [N_PINS-1:0]  stat_vec;
  logic [SENSE_W-1:0] sense_cfg;

  xirq_sync #(.W(N_PINS)) u_sync (
    .clk (clk), .rst (rst), .d (pin_i), .s_q (pin_s), .p_q (pin_p)
  );

  xirq_regs #(.N_PINS(N_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk (clk), .rst (rst), .we (bus_we), .addr (bus_addr),
    .wdata (bus_wdata), .stat (stat_vec), .sense_q (sense_cfg),
    .clr (clr_vec), .rdata (bus_rdata)
  );

  for (genvar n = 0; n < N_PINS; n++) begin : g_chan
    xirq_chan u_chan (
      .clk (clk), .rst (rst), .mode (sense_cfg[2*n +: 2]),
      .s (pin_s[n]), .p (pin_p[n]), .clr (clr_vec[n]),
      .stat_q (stat_vec[n])
    );
  end

  assign irq_req = stat_vec;
endmodule

// File: rtl/xirq_checker.sv
module xirq_checker #(
  parameter int N_PINS = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic [N_PINS-1:0]   pin_i,
  input logic                bus_we,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [N_PINS-1:0]   irq_req,
  input logic [2*N_PINS-1:0] sense
);
  logic [2:0] cyc;
  logic       st_acc;
  logic       se_acc;

  always_ff @(posedge clk) begin
    if (rst)               cyc <= '0;
    else if (cyc != 3'd7)  cyc <= cyc + 3'd1;
  end

  assign st_acc = (bus_addr == ADDR_W'(8'h10));
  assign se_acc = (bus_addr == ADDR_W'(8'h14));

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (irq_req == '0 && bus_rdata == '0));

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd1 && !$past(st_acc) && !$past(se_acc)) |-> bus_rdata == '0);

  p_status_read_r8: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd1 && $past(st_acc)) |-> bus_rdata == DATA_W'($past(irq_req)));

  for (genvar n = 0; n < N_PINS; n++) begin : g_pin
    p_sticky_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (sense[2*n +: 2] != 2'd0 && irq_req[n] &&
       !(bus_we && st_acc && !bus_wdata[n])) |=> irq_req[n]);

    p_level_follow_r3: assert property (@(posedge clk) disable iff (rst)
      (cyc >= 3'd4 && $past(sense[2*n +: 2]) == 2'd0) |->
        irq_req[n] == !$past(pin_i[n], 3));
  end
endmodule

bind ext_irq_sense xirq_checker #(
  .N_PINS(N_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk (clk), .rst (rst), .pin_i (pin_i), .bus_we (bus_we),
  .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
  .irq_req (irq_req), .sense (sense_cfg)
);

// File: tb/ext_irq_sense_bench.sv
module ext_irq_sense_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pin_i = 8'hFF;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  irq_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] cfg;
  logic [7:0]  exp_st;
  logic [31:0] rv;

  always #10 clk = ~clk;

  ext_irq_sense u_ext_irq_sense (
    .clk (clk), .rst (rst), .pin_i (pin_i), .bus_we (bus_we),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .irq_req (irq_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_addr = 8'h00;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // Edge-mode hit for one pin per sense code (0 level, 1 fall, 2 rise, 3 both).
  function automatic logic hit(input logic [1:0] m, input logic o, input logic n);
    case (m)
      2'd1: return o & ~n;
      2'd2: return ~o & n;
      2'd3: return o ^ n;
      default: return 1'b0;
    endcase
  endfunction

  // Expected status after pins move from o to n, starting from st.
  function automatic logic [7:0] step(input logic [15:0] c, input logic [7:0] st,
                                      input logic [7:0] o, input logic [7:0] n);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      if (c[2*i +: 2] == 2'd0) r[i] = ~n[i];
      else                     r[i] = st[i] | hit(c[2*i +: 2], o[i], n[i]);
    end
    return r;
  endfunction

  // Expected status after a status write with mask w.
  function automatic logic [7:0] clear(input logic [15:0] c, input logic [7:0] st,
                                       input logic [7:0] w);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = (c[2*i +: 2] == 2'd0) ? st[i] : (st[i] & w[i]);
    return r;
  endfunction

  task automatic set_pins(input logic [7:0] v, input string tag);
    logic [7:0] o;
    o = pin_i;
    @(negedge clk);
    pin_i = v;
    settle();
    exp_st = step(cfg, exp_st, o, v);
    check({tag, " req"}, {24'h0, irq_req}, {24'h0, exp_st});
    rd(8'h10, rv);
    check({tag, " status read"}, rv, {24'h0, exp_st});
  endtask

  task automatic set_cfg(input logic [15:0] c);
    cfg = c;
    wr(8'h14, {16'h0, c});
    wr(8'h10, 32'h0);
    settle();
    exp_st = clear(cfg, step(cfg, 8'h00, pin_i, pin_i), 8'h00);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    cfg = 16'h0; exp_st = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 req after reset", {24'h0, irq_req}, 32'h0);
    rd(8'h10, rv); check("R1 status after reset", rv, 32'h0);
    rd(8'h14, rv); check("R1 sense after reset", rv, 32'h0);

    // R2 sense field readback, R10 unmapped offset
    wr(8'h14, 32'hFFFF_1BE4);
    rd(8'h14, rv); check("R2 sense readback", rv, 32'h0000_1BE4);
    rd(8'h18, rv); check("R10 unmapped read", rv, 32'h0);
    rd(8'h00, rv); check("R10 offset 0 read", rv, 32'h0);

    // R3 level low
    set_cfg(16'h0000);
    set_pins(8'hA5, "R3 level follow");
    wr(8'h10, 32'h0); settle();
    check("R3 clear ignored in level mode", {24'h0, irq_req}, 32'h0000_005A);
    set_pins(8'hFF, "R3 level release");

    // R4 falling, R7 opposite edge
    set_cfg(16'h5555);
    set_pins(8'h0F, "R4 falling set");
    set_pins(8'hFF, "R7 rising ignored in falling mode");
    // R8 clear 0 / keep 1
    wr(8'h10, 32'hFFFF_FFCF); settle(); exp_st = clear(cfg, exp_st, 8'hCF);
    check("R8 partial clear", {24'h0, irq_req}, 32'h0000_00C0);
    wr(8'h10, 32'h0); settle(); exp_st = 8'h00;
    check("R8 clear all", {24'h0, irq_req}, 32'h0);

    // R5 rising, R7 falling ignored
    set_cfg(16'hAAAA);
    set_pins(8'h00, "R7 falling ignored in rising mode");
    set_pins(8'h3C, "R5 rising set");

    // R6 both edges
    set_cfg(16'hFFFF);
    set_pins(8'h30, "R6 falling in both mode");
    wr(8'h10, 32'h0); settle(); exp_st = 8'h00;
    set_pins(8'h31, "R6 rising in both mode");

    // R9 edge in the same cycle as a clear
    set_pins(8'hFF, "R9 prep");
    set_cfg(16'h5555);
    check("R9 status clean before", {24'h0, irq_req}, 32'h0);
    @(negedge clk); pin_i = 8'hFE;
    @(negedge clk);
    @(negedge clk); bus_we = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h0;
    @(negedge clk); bus_we = 1'b0; bus_addr = 8'h00;
    settle();
    check("R9 edge wins over clear", {24'h0, irq_req}, 32'h0000_0001);
    exp_st = 8'h01;

    // Random mixed modes
    for (int it = 0; it < 150; it++) begin
      if (it % 10 == 0) set_cfg(16'($urandom()));
      set_pins(8'($urandom()), "R10 random pins");
      begin
        logic [7:0] m;
        m = 8'($urandom());
        wr(8'h10, {24'hFFFFFF, m});
        settle();
        exp_st = clear(cfg, exp_st, m);
        check("R8 random clear", {24'h0, irq_req}, {24'h0, exp_st});
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule